// File: doc/BRIEF.md
# Predicated Vector Element Issue Splitter

The block takes one vectorised scalar operation at a time and turns it into per-element operations for an ALU with `LANES` issue slots. Each operation brings a vector length, a predicate bitmask, a vector/scalar flag and a base register number for the destination and for two sources. It also brings a zeroing option. Every cycle the block gathers up to `LANES` of the remaining elements. It places them on the lowest lanes in ascending element order and presents them as one issue group. It keeps whatever is left over for the following cycles.

Both data interfaces use valid/ready. An operation is accepted in a cycle where `op_valid` and `op_ready` are both high. `op_ready` is high only while no operation is in progress, so the operation input is back-pressured for the whole time one is being split. An issue group is consumed in a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low, the presented group does not change in any field. `iss_last` marks the final group of an operation. The plain pin `op_done` pulses for one cycle after an operation has fully drained.

Top module: `pred_issue_split`

## Requirements
- R1: After reset, `op_ready` is 1, `iss_valid` is 0 and `op_done` is 0.
- R2: With zeroing off, element i is issued only if bit i of `op_mask` is 1. If no element qualifies, nothing is issued. Each issued lane reports its element number on `iss_idx` (lane k in bits [k*IW +: IW]).
- R3: Qualifying elements go out in ascending element order and fill lanes from lane 0 upward. Each group holds `LANES` elements, except the final group, which holds the remainder. Eight elements with six enabled take two groups (4, then 2) at `LANES`=4. `iss_lane_en` bit k marks lane k as occupied.
- R4: For an element i, an operand whose vector flag is 1 uses register (base + i) mod 2^RW, and an operand whose flag is 0 uses its base for every element. The offset follows the element number, so skipped elements still advance it.
- R5: With `op_zero` set, every element below the vector length is issued. `iss_zero` bit k is 1 exactly when the element on lane k has a clear predicate bit.
- R6: Elements at or above `op_vlen` are never issued, and lengths above XLEN act as XLEN. A length of 0 issues nothing, and `op_done` is 1 in the cycle after acceptance.
- R7: While `iss_valid` is 1 and `iss_ready` is 0, every issue output holds its value into the next cycle.
- R8: `op_ready` is 0 while an operation has groups left to issue, and `op_valid` is ignored in that time.
- R9: `iss_last` is 1 only on the final group. `op_done` is 1 in exactly the cycle after that group's handshake, and `iss_valid` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be accepted (idle) |
| op_vlen | input | LW | Vector length, 0 to XLEN |
| op_mask | input | XLEN | Predicate bitmask, bit i for element i |
| op_zero | input | 1 | Zeroing mode: issue disabled elements flagged for zero write |
| op_vec_d | input | 1 | Destination is a vector |
| op_vec_a | input | 1 | Source A is a vector |
| op_vec_b | input | 1 | Source B is a vector |
| op_rd | input | RW | Destination base register |
| op_ra | input | RW | Source A base register |
| op_rb | input | RW | Source B base register |
| iss_valid | output | 1 | Issue group presented |
| iss_ready | input | 1 | ALU takes the group |
| iss_lane_en | output | LANES | Lane occupied |
| iss_zero | output | LANES | Lane writes zero to its destination |
| iss_idx | output | LANES*IW | Element number per lane |
| iss_rd | output | LANES*RW | Destination register per lane |
| iss_ra | output | LANES*RW | Source A register per lane |
| iss_rb | output | LANES*RW | Source B register per lane |
| iss_last | output | 1 | Final group of the operation |
| op_done | output | 1 | One-cycle pulse after the operation drains |

## Verification
The bench builds the block with its defaults: four lanes, a 32-bit predicate and 5-bit register numbers. Four lanes make a partial final group possible and allow the six-of-eight case to split as 4 then 2. The full 32-bit width allows a length equal to XLEN, a length above it that must clamp, and element 31 as the only high element. With 5-bit register numbers, bases near 31 can wrap as the offset grows, and the bench checks that wrap alongside scalar operands held fixed, zeroing lanes, and a stalled group with a competing operation waiting at the input.

// File: rtl/vis_pkg.sv
package vis_pkg;
  // which operands step through registers per element
  typedef struct packed {
    logic dst;
    logic src_a;
    logic src_b;
  } vflag_t;
endpackage

// File: rtl/vis_pick.sv
module vis_pick #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  rest
);
  // lowest set bit wins: scan high to low so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int j = W - 1; j >= 0; j--) begin
      if (vec[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end

  assign rest = vec & (vec - 1'b1);
endmodule

// File: rtl/vis_addr.sv
module vis_addr #(
  parameter int IW = 5,
  parameter int RW = 5
) (
  input  logic [IW-1:0] idx,
  input  logic [RW-1:0] base,
  input  logic          is_vec,
  output logic [RW-1:0] regno
);
  // offset from the element number, wrapping in the register space
  assign regno = is_vec ? base + RW'(idx) : base;
endmodule

// File: rtl/pred_issue_split.sv
module pred_issue_split #(
  parameter int LANES = 4,
  parameter int XLEN  = 32,
  parameter int RW    = 5,
  localparam int IW   = (XLEN > 1) ? $clog2(XLEN) : 1,
  localparam int LW   = $clog2(XLEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic [LW-1:0]       op_vlen,
  input  logic [XLEN-1:0]     op_mask,
  input  logic                op_zero,
  input  logic                op_vec_d,
  input  logic                op_vec_a,
  input  logic                op_vec_b,
  input  logic [RW-1:0]       op_rd,
  input  logic [RW-1:0]       op_ra,
  input  logic [RW-1:0]       op_rb,
  output logic                iss_valid,
  input  logic                iss_ready,
  output logic [LANES-1:0]    iss_lane_en,
  output logic [LANES-1:0]    iss_zero,
  output logic [LANES*IW-1:0] iss_idx,
  output logic [LANES*RW-1:0] iss_rd,
  output logic [LANES*RW-1:0] iss_ra,
  output logic [LANES*RW-1:0] iss_rb,
  output logic                iss_last,
  output logic                op_done
);
  import vis_pkg::*;

  logic            busy;
  logic [XLEN-1:0] pend;
  logic [XLEN-1:0] zmask;
  vflag_t          vf;
  logic [RW-1:0]   base_d, base_a, base_b;
  logic            done_q;

  // elements below the vector length
  logic [XLEN-1:0] lenmask;
  for (genvar i = 0; i < XLEN; i++) begin : g_len
    assign lenmask[i] = (op_vlen > LW'(i));
  end

  logic [XLEN-1:0] first_pend;
  logic [XLEN-1:0] first_zero;
  assign first_pend = lenmask & (op_zero ? {XLEN{1'b1}} : op_mask);
  assign first_zero = op_zero ? (lenmask & ~op_mask) : '0;

  // chained pickers pack the lowest pending elements onto the lanes
  logic [XLEN-1:0] chain [LANES+1];
  logic [IW-1:0]   lane_idx [LANES];
  logic [LANES-1:0] lane_found;
  assign chain[0] = pend;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [RW-1:0] rd_k, ra_k, rb_k;

    vis_pick #(.W(XLEN), .IW(IW)) u_pick (
      .vec   (chain[k]),
      .found (lane_found[k]),
      .idx   (lane_idx[k]),
      .rest  (chain[k+1])
    );

    vis_addr #(.IW(IW), .RW(RW)) u_ad (
      .idx(lane_idx[k]), .base(base_d), .is_vec(vf.dst), .regno(rd_k));
    vis_addr #(.IW(IW), .RW(RW)) u_aa (
      .idx(lane_idx[k]), .base(base_a), .is_vec(vf.src_a), .regno(ra_k));
    vis_addr #(.IW(IW), .RW(RW)) u_ab (
      .idx(lane_idx[k]), .base(base_b), .is_vec(vf.src_b), .regno(rb_k));

    assign iss_lane_en[k]         = busy & lane_found[k];
    assign iss_zero[k]            = iss_lane_en[k] & zmask[lane_idx[k]];
    assign iss_idx[k*IW +: IW]    = iss_lane_en[k] ? lane_idx[k] : '0;
    assign iss_rd[k*RW +: RW]     = iss_lane_en[k] ? rd_k : '0;
    assign iss_ra[k*RW +: RW]     = iss_lane_en[k] ? ra_k : '0;
    assign iss_rb[k*RW +: RW]     = iss_lane_en[k] ? rb_k : '0;

    if (k > 0) begin : g_chk
      p_pack_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_lane_en[k] |-> iss_lane_en[k-1]);
      p_pack_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_lane_en[k] |-> (lane_idx[k] > lane_idx[k-1]));
    end
  end

  assign iss_valid = busy;
  assign op_ready  = ~busy;
  assign iss_last  = busy & ~|chain[LANES];
  assign op_done   = done_q;

  wire accept = op_valid & op_ready;
  wire fire   = iss_valid & iss_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= '0;
      zmask  <= '0;
      vf     <= '0;
      base_d <= '0;
      base_a <= '0;
      base_b <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      pend   <= first_pend;
      zmask  <= first_zero;
      vf     <= '{dst: op_vec_d, src_a: op_vec_a, src_b: op_vec_b};
      base_d <= op_rd;
      base_a <= op_ra;
      base_b <= op_rb;
      busy   <= |first_pend;
      done_q <= ~|first_pend;
    end else if (fire) begin
      pend   <= chain[LANES];
      busy   <= |chain[LANES];
      done_q <= ~|chain[LANES];
    end else begin
      done_q <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_lane_en)
      && $stable(iss_idx) && $stable(iss_rd) && $stable(iss_ra)
      && $stable(iss_rb) && $stable(iss_zero) && $stable(iss_last));

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !iss_valid);

  p_last_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && iss_last |=> op_done && !iss_valid);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> !iss_valid);
endmodule

// File: tb/tb_pred_issue_split.sv
`timescale 1ns/1ps
module tb_pred_issue_split;
  localparam int LANES = 4;
  localparam int XLEN  = 32;
  localparam int RW    = 5;
  localparam int IW    = 5;
  localparam int LW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic op_ready;
  logic [LW-1:0] op_vlen = '0;
  logic [XLEN-1:0] op_mask = '0;
  logic op_zero = 1'b0, op_vec_d = 1'b0, op_vec_a = 1'b0, op_vec_b = 1'b0;
  logic [RW-1:0] op_rd = '0, op_ra = '0, op_rb = '0;
  logic iss_valid;
  logic iss_ready = 1'b0;
  logic [LANES-1:0] iss_lane_en, iss_zero;
  logic [LANES*IW-1:0] iss_idx;
  logic [LANES*RW-1:0] iss_rd, iss_ra, iss_rb;
  logic iss_last, op_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pred_issue_split #(.LANES(LANES), .XLEN(XLEN), .RW(RW)) dut (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one operation end to end; stall_grp < 0 means no stall
  task automatic run_op(input string tag, input int vlen, input logic [31:0] mask,
                        input bit z, input bit vd, input bit va, input bit vb,
                        input int rd, input int ra, input int rb,
                        input int stall_grp, input bit junk);
    int el[32];
    int n = 0;
    int lim = (vlen > XLEN) ? XLEN : vlen;
    for (int i = 0; i < lim; i++)
      if (z || mask[i]) begin el[n] = i; n++; end

    @(negedge clk);
    check(op_ready === 1'b1, tag, "ready before op", 128'(op_ready), 128'd1);
    op_valid = 1'b1; op_vlen = LW'(vlen); op_mask = mask; op_zero = z;
    op_vec_d = vd; op_vec_a = va; op_vec_b = vb;
    op_rd = RW'(rd); op_ra = RW'(ra); op_rb = RW'(rb);
    iss_ready = 1'b0;
    @(negedge clk);
    op_valid = junk;
    if (junk) begin
      op_vlen = 6'd3; op_mask = '1; op_rd = 5'd7; op_vec_d = 1'b1;
    end

    if (n == 0) begin
      check(iss_valid === 1'b0 && op_done === 1'b1, tag, "empty op done",
            128'({iss_valid, op_done}), 128'b01);
    end else begin
      for (int g = 0; g * LANES < n; g++) begin
        logic [LANES-1:0] e_en = '0, e_z = '0;
        logic [LANES*IW-1:0] e_idx = '0;
        logic [LANES*RW-1:0] e_rd = '0, e_ra = '0, e_rb = '0;
        bit e_last = ((g + 1) * LANES >= n);
        logic [127:0] got, exp;
        for (int k = 0; k < LANES; k++) begin
          int p = g * LANES + k;
          if (p < n) begin
            e_en[k] = 1'b1;
            e_z[k] = z && !mask[el[p]];
            e_idx[k*IW +: IW] = IW'(el[p]);
            e_rd[k*RW +: RW] = RW'(rd + (vd ? el[p] : 0));
            e_ra[k*RW +: RW] = RW'(ra + (va ? el[p] : 0));
            e_rb[k*RW +: RW] = RW'(rb + (vb ? el[p] : 0));
          end
        end
        exp = 128'({1'b1, e_last, e_en, e_z, e_idx, e_rd, e_ra, e_rb});
        got = 128'({iss_valid, iss_last, iss_lane_en, iss_zero, iss_idx, iss_rd, iss_ra, iss_rb});
        check(got === exp, tag, $sformatf("group %0d", g), got, exp);
        check(op_ready === 1'b0, "R8", "ready while busy", 128'(op_ready), 128'd0);
        if (g == stall_grp) begin
          @(negedge clk);
          got = 128'({iss_valid, iss_last, iss_lane_en, iss_zero, iss_idx, iss_rd, iss_ra, iss_rb});
          check(got === exp, "R7", "held under stall", got, exp);
        end
        iss_ready = 1'b1;
        if (e_last) op_valid = 1'b0;
        @(negedge clk);
        iss_ready = 1'b0;
      end
      check(op_done === 1'b1 && iss_valid === 1'b0, "R9", "done after last",
            128'({op_done, iss_valid}), 128'b10);
    end
    op_valid = 1'b0;
    @(negedge clk);
    check(op_done === 1'b0, "R9", "done is a pulse", 128'(op_done), 128'd0);
  endtask

  task automatic t_reset();
    check(op_ready === 1'b1 && iss_valid === 1'b0 && op_done === 1'b0, "R1",
          "reset state", 128'({op_ready, iss_valid, op_done}), 128'b100);
  endtask

  // R2 R3 R4: six of eight enabled, 4 then 2
  task automatic t_sparse();
    run_op("R3", 8, 32'b1011_1101, 0, 1, 1, 0, 2, 10, 20, -1, 0);
  endtask

  // R4 R6: full length, destination wraps past 31
  task automatic t_full();
    run_op("R4", 32, 32'hFFFF_FFFF, 0, 1, 0, 1, 30, 4, 28, -1, 0);
  endtask

  // R6: length cut and clamp above XLEN
  task automatic t_len();
    run_op("R6", 5, 32'hFFFF_FFFF, 0, 1, 1, 1, 0, 1, 2, -1, 0);
    run_op("R6", 40, 32'h8000_0001, 0, 1, 1, 1, 3, 3, 3, -1, 0);
  endtask

  // R6 R2: nothing to issue
  task automatic t_empty();
    run_op("R6", 0, 32'hFFFF_FFFF, 0, 1, 1, 1, 0, 0, 0, -1, 0);
    run_op("R2", 8, 32'h0000_FF00, 0, 1, 1, 1, 0, 0, 0, -1, 0);
  endtask

  // R5: zeroing issues every element, flags the disabled ones
  task automatic t_zero();
    run_op("R5", 6, 32'b10_0100, 1, 1, 0, 1, 8, 9, 12, -1, 0);
  endtask

  // R4 scalars fixed; R7 R8 stall with an operation waiting
  task automatic t_stall();
    run_op("R4", 7, 32'b101_0110, 0, 0, 0, 0, 5, 6, 7, 0, 1);
    run_op("R7", 9, 32'h1FF, 0, 1, 1, 0, 1, 1, 1, 1, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sparse();
    t_full();
    t_len();
    t_empty();
    t_zero();
    t_stall();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule